// File: doc/BRIEF.md
# Deterministic hard reset sequencer

This block runs the hard-reset sequence of a node controller that sits between a memory subsystem and a processor bus. Its job is to make the first processor request after a reset arrive at a fixed time relative to the chipset clocks. It does this by tying the release of reset to the boundaries of the periodic memory maintenance cycle. A reset can come from the synchronous external reset input, or from a self-clearing software reset bit. Once a sequence has started, the block drives the processor bus block-next-request line and the processor reset line. At the moment reset is released, it pulses clears to the DRAM refresh interval counter and to the write-buffer timing conflict trackers.

When a software reset is requested and memory preservation is enabled, the sequence is deterministic. After the assertion phase it waits for a maintenance-cycle end, which is the synchronization point. It then toggles block-next-request until the following maintenance-cycle end, and only then enters the release phase.

Every other case takes a fallback path. That means an external reset, or a software reset with preservation disabled. The fallback goes straight from assertion to release and raises a non-deterministic flag. During release, the reset cause decides the output behaviour. A bus-init cause keeps block-next-request toggling and drops processor reset. Any other cause holds block-next-request inactive and keeps processor reset asserted. The block also holds a preserve-configuration bit, which any external reset clears.

Top module: `hrst_align_seq`

## Requirements
- R1: After the asynchronous reset the sequencer state reads idle and every output reads 0. The state codes on `seq_state_o` are idle=0, assert=1, wait-sync=2, toggle=3 and release=4.
- R2: A strobe on `sw_rst_set` sets `sw_rst_bit_o`. With no external reset present, the state becomes assert on the clock edge that comes HOLDOFF+1 edges after the edge that captured the strobe. Assert then lasts one cycle.
- R3: When `ext_rst` is sampled high, the state becomes assert on the next edge from any state, and stays there while the input stays high. In assert, `cpu_rst_o`=1 and `bnr_o`=1.
- R4: On a deterministic sequence (software start with `keep_mem_en`=1), assert is followed by wait-sync, with `bnr_o`=1 and `cpu_rst_o`=1. The state moves to toggle on the edge after a sampled `maint_end`. A `maint_end` pulse given before wait-sync has no effect on this wait.
- R5: In toggle, `bnr_o` inverts on every cycle, and `cpu_rst_o`=1. The state moves to release on the edge after the next sampled `maint_end`.
- R6: For a non-bus-init cause (`cause_businit`=0 when the sequence started), release lasts RELEASE_LEN cycles with `bnr_o`=0 and `cpu_rst_o`=1. The state then returns to idle with both outputs at 0.
- R7: For a bus-init cause, `bnr_o` keeps inverting on every release cycle and `cpu_rst_o`=0.
- R8: `refresh_clr_o` and `tracker_clr_o` are both 1 in the first release cycle only.
- R9: `sw_rst_bit_o` reads 0 once the sequence has returned to idle after release.
- R10: A strobe on `cfg_keep_set` sets `keep_cfg_o`. Any cycle with `ext_rst` sampled high clears it, and the clear takes priority over the strobe.
- R11: An external reset, or a software start with `keep_mem_en`=0, goes straight from assert to release with no wait-sync or toggle, and sets `nondet_o`=1. A deterministic start sets `nondet_o`=0. The flag holds its value through idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rst | input | 1 | Synchronous external reset request, active high |
| maint_end | input | 1 | One-cycle pulse at the end of a memory maintenance cycle |
| keep_mem_en | input | 1 | Preserve-memory enable, which allows aligned release |
| cause_businit | input | 1 | Reset cause: 1 = bus-init, 0 = other |
| sw_rst_set | input | 1 | Write strobe that sets the software reset bit |
| cfg_keep_set | input | 1 | Write strobe that sets the preserve-configuration bit |
| bnr_o | output | 1 | Processor bus block-next-request |
| cpu_rst_o | output | 1 | Reset toward the processors |
| refresh_clr_o | output | 1 | Clear pulse for the refresh interval counter |
| tracker_clr_o | output | 1 | Clear pulse for the write-buffer conflict trackers |
| sw_rst_bit_o | output | 1 | Self-clearing software reset bit |
| keep_cfg_o | output | 1 | Preserve-configuration bit |
| nondet_o | output | 1 | Last sequence was not aligned to a maintenance cycle |
| seq_state_o | output | 3 | Current sequencer state code |

## Verification
The hardest situations to reach are the two maintenance-cycle alignments, and an external reset that cuts into an aligned sequence. Reaching them takes a software start with preservation enabled, followed by `maint_end` pulses placed at chosen cycle offsets inside wait-sync and toggle. The stimulus sweeps trigger source, preservation enable, cause and both pulse offsets. It adds a stray `maint_end` before wait-sync to show that pulse is ignored. A separate run raises `ext_rst` in the middle of toggle and checks that the sequence restarts on the fallback path.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ASRT  = 3'd1,
    ST_WSYNC = 3'd2,
    ST_TOGL  = 3'd3,
    ST_REL   = 3'd4
  } seq_st_t;
endpackage

// File: rtl/hrs_dncnt.sv
module hrs_dncnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/hrs_ctrl_bits.sv
module hrs_ctrl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic cfg_set,
  input  logic ext_rst,
  input  logic seq_done,
  output logic sw_bit,
  output logic keep_cfg
);
  logic sw_q, sw_d, cfg_q, cfg_d;

  always_comb begin
    sw_d = sw_q;
    if (sw_set)        sw_d = 1'b1;
    else if (seq_done) sw_d = 1'b0;
    cfg_d = cfg_q;
    if (ext_rst)       cfg_d = 1'b0;
    else if (cfg_set)  cfg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= 1'b0;
      cfg_q <= 1'b0;
    end else begin
      sw_q  <= sw_d;
      cfg_q <= cfg_d;
    end
  end

  assign sw_bit   = sw_q;
  assign keep_cfg = cfg_q;

  a_r10_ext_clears_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> !keep_cfg);
endmodule

// File: rtl/hrs_fsm.sv
module hrs_fsm
  import hrs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ext_rst,
  input  logic    sw_go,
  input  logic    keep_mem_en,
  input  logic    cause_businit,
  input  logic    maint_end,
  input  logic    rel_zero,
  output seq_st_t state,
  output logic    enter_rel,
  output logic    rel_done,
  output logic    bnr,
  output logic    cpu_rst,
  output logic    clr,
  output logic    nondet
);
  seq_st_t st_q, st_d;
  logic det_q, det_d, bi_q, bi_d, nd_q, nd_d;
  logic bnr_q, bnr_d, cpu_q, cpu_d, clr_q, clr_d;
  logic start;

  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    if (ext_rst) begin
      st_d  = ST_ASRT;
      start = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (sw_go) begin st_d = ST_ASRT; start = 1'b1; end
        ST_ASRT:  st_d = det_q ? ST_WSYNC : ST_REL;
        ST_WSYNC: if (maint_end) st_d = ST_TOGL;
        ST_TOGL:  if (maint_end) st_d = ST_REL;
        ST_REL:   if (rel_zero)  st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    det_d = start ? (!ext_rst && keep_mem_en) : det_q;
    bi_d  = start ? cause_businit : bi_q;
    nd_d  = start ? !det_d : nd_q;
    enter_rel = (st_d == ST_REL) && (st_q != ST_REL);
    rel_done  = (st_q == ST_REL) && rel_zero && !ext_rst;
    clr_d     = enter_rel;
    unique case (st_d)
      ST_ASRT, ST_WSYNC: begin bnr_d = 1'b1;            cpu_d = 1'b1;  end
      ST_TOGL:           begin bnr_d = !bnr_q;          cpu_d = 1'b1;  end
      ST_REL:            begin bnr_d = bi_d && !bnr_q;  cpu_d = !bi_d; end
      default:           begin bnr_d = 1'b0;            cpu_d = 1'b0;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      det_q <= 1'b0;
      bi_q  <= 1'b0;
      nd_q  <= 1'b0;
      bnr_q <= 1'b0;
      cpu_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      det_q <= det_d;
      bi_q  <= bi_d;
      nd_q  <= nd_d;
      bnr_q <= bnr_d;
      cpu_q <= cpu_d;
      clr_q <= clr_d;
    end
  end

  assign state   = st_q;
  assign bnr     = bnr_q;
  assign cpu_rst = cpu_q;
  assign clr     = clr_q;
  assign nondet  = nd_q;

  a_r3_ext_enters_assert: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> (st_q == ST_ASRT));
  a_r4_sync_on_maint_end: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TOGL && $past(st_q) == ST_WSYNC) |-> $past(maint_end));
  a_r5_bnr_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TOGL) |-> (bnr_q != $past(bnr_q)));
  a_r5_cpu_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WSYNC || st_q == ST_TOGL) |-> cpu_q);
  a_r6_release_other: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REL && !bi_q) |-> (!bnr_q && cpu_q));
  a_r8_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
endmodule

// File: rtl/hrst_align_seq.sv
module hrst_align_seq
  import hrs_pkg::*;
#(
  parameter int HOLDOFF     = 16,
  parameter int RELEASE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rst,
  input  logic       maint_end,
  input  logic       keep_mem_en,
  input  logic       cause_businit,
  input  logic       sw_rst_set,
  input  logic       cfg_keep_set,
  output logic       bnr_o,
  output logic       cpu_rst_o,
  output logic       refresh_clr_o,
  output logic       tracker_clr_o,
  output logic       sw_rst_bit_o,
  output logic       keep_cfg_o,
  output logic       nondet_o,
  output logic [2:0] seq_state_o
);
  localparam int HW = (HOLDOFF > 1) ? $clog2(HOLDOFF + 1) : 1;
  localparam int RW = (RELEASE_LEN > 1) ? $clog2(RELEASE_LEN) : 1;
  localparam logic [HW-1:0] HOLD_V = HW'(HOLDOFF);
  localparam logic [RW-1:0] REL_V  = RW'(RELEASE_LEN - 1);

  seq_st_t state;
  logic hold_zero, rel_zero, enter_rel, rel_done, sw_go, clr, sw_bit;

  assign sw_go = sw_bit && hold_zero && !sw_rst_set;

  hrs_dncnt #(.W(HW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(sw_rst_set), .load_val(HOLD_V), .zero(hold_zero));

  hrs_dncnt #(.W(RW)) u_rel (
    .clk(clk), .rst_n(rst_n), .load(enter_rel), .load_val(REL_V), .zero(rel_zero));

  hrs_ctrl_bits u_bits (
    .clk(clk), .rst_n(rst_n), .sw_set(sw_rst_set), .cfg_set(cfg_keep_set),
    .ext_rst(ext_rst), .seq_done(rel_done), .sw_bit(sw_bit), .keep_cfg(keep_cfg_o));

  hrs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .sw_go(sw_go),
    .keep_mem_en(keep_mem_en), .cause_businit(cause_businit),
    .maint_end(maint_end), .rel_zero(rel_zero), .state(state),
    .enter_rel(enter_rel), .rel_done(rel_done), .bnr(bnr_o),
    .cpu_rst(cpu_rst_o), .clr(clr), .nondet(nondet_o));

  assign refresh_clr_o = clr;
  assign tracker_clr_o = clr;
  assign sw_rst_bit_o  = sw_bit;
  assign seq_state_o   = state;

  a_r2_sw_start_after_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_IDLE && state == ST_ASRT && !$past(ext_rst)) |-> $past(hold_zero));
  a_r9_bit_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_bit) |-> ($past(state) == ST_REL));
endmodule

// File: tb/hrst_align_seq_tb.sv
`timescale 1ns/1ps
module hrst_align_seq_tb;
  localparam int H  = 5;
  localparam int RL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst = 0, maint_end = 0, keep_mem_en = 0, cause_businit = 0;
  logic sw_rst_set = 0, cfg_keep_set = 0;
  logic bnr_o, cpu_rst_o, refresh_clr_o, tracker_clr_o, sw_rst_bit_o, keep_cfg_o, nondet_o;
  logic [2:0] seq_state_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hrst_align_seq #(.HOLDOFF(H), .RELEASE_LEN(RL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .maint_end(maint_end),
    .keep_mem_en(keep_mem_en), .cause_businit(cause_businit),
    .sw_rst_set(sw_rst_set), .cfg_keep_set(cfg_keep_set), .bnr_o(bnr_o),
    .cpu_rst_o(cpu_rst_o), .refresh_clr_o(refresh_clr_o),
    .tracker_clr_o(tracker_clr_o), .sw_rst_bit_o(sw_rst_bit_o),
    .keep_cfg_o(keep_cfg_o), .nondet_o(nondet_o), .seq_state_o(seq_state_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_rel(input bit bi, inout logic prev, input bit first);
    chk(seq_state_o == 3'd4, "R6 release state", seq_state_o, 4);
    chk(refresh_clr_o == first && tracker_clr_o == first, "R8 clear pulses",
        {refresh_clr_o, tracker_clr_o}, first ? 3 : 0);
    if (bi) begin
      chk(bnr_o != prev, "R7 bnr toggles in release", bnr_o, !prev);
      chk(cpu_rst_o == 1'b0, "R7 cpu reset dropped", cpu_rst_o, 0);
    end else begin
      chk(bnr_o == 1'b0, "R6 bnr inactive", bnr_o, 0);
      chk(cpu_rst_o == 1'b1, "R6 cpu reset held", cpu_rst_o, 1);
    end
    prev = bnr_o;
  endtask

  task automatic run_seq(input bit ext, input bit keep, input bit bi, input int g1, input int g2);
    logic prev;
    int n;
    bit det;
    det = !ext && keep;
    keep_mem_en = keep;
    cause_businit = bi;
    if (ext) begin
      cfg_keep_set = 1; tick(); cfg_keep_set = 0; tick();
      chk(keep_cfg_o == 1'b1, "R10 cfg bit set", keep_cfg_o, 1);
      ext_rst = 1; maint_end = 1; cfg_keep_set = 1;
      tick();
      maint_end = 0; cfg_keep_set = 0;
      chk(seq_state_o == 3'd1, "R3 assert on ext", seq_state_o, 1);
      chk(cpu_rst_o && bnr_o, "R3 outputs in assert", {cpu_rst_o, bnr_o}, 3);
      chk(keep_cfg_o == 1'b0, "R10 ext clears cfg", keep_cfg_o, 0);
      tick();
      chk(seq_state_o == 3'd1, "R3 stays in assert", seq_state_o, 1);
      ext_rst = 0;
    end else begin
      sw_rst_set = 1; maint_end = 1;
      tick();
      sw_rst_set = 0; maint_end = 0;
      chk(sw_rst_bit_o == 1'b1, "R2 sw bit set", sw_rst_bit_o, 1);
      n = 1;
      while (seq_state_o != 3'd1 && n < 60) begin tick(); n++; end
      chk(n == H + 2, "R2 holdoff length", n, H + 2);
    end
    chk(nondet_o == !det, "R11 nondet flag", nondet_o, !det);
    prev = bnr_o;
    tick();
    if (det) begin
      chk(seq_state_o == 3'd2, "R4 wait-sync", seq_state_o, 2);
      chk(bnr_o && cpu_rst_o, "R4 outputs in wait-sync", {bnr_o, cpu_rst_o}, 3);
      for (int i = 0; i < g1; i++) begin
        tick();
        chk(seq_state_o == 3'd2, "R4 waits for maint_end", seq_state_o, 2);
      end
      prev = bnr_o;
      maint_end = 1; tick(); maint_end = 0;
      chk(seq_state_o == 3'd3, "R4 toggle after sync", seq_state_o, 3);
      chk(bnr_o != prev, "R5 bnr inverts", bnr_o, !prev);
      chk(cpu_rst_o == 1'b1, "R5 cpu reset held", cpu_rst_o, 1);
      prev = bnr_o;
      for (int i = 0; i < g2; i++) begin
        tick();
        chk(seq_state_o == 3'd3 && bnr_o != prev, "R5 toggling",
            {seq_state_o, bnr_o}, {3'd3, !prev});
        prev = bnr_o;
      end
      maint_end = 1; tick(); maint_end = 0;
    end
    chk_rel(bi, prev, 1'b1);
    for (int i = 1; i < RL; i++) begin
      tick();
      chk_rel(bi, prev, 1'b0);
    end
    tick();
    chk(seq_state_o == 3'd0, "R6 back to idle", seq_state_o, 0);
    chk(!bnr_o && !cpu_rst_o, "R6 outputs idle", {bnr_o, cpu_rst_o}, 0);
    chk(sw_rst_bit_o == 1'b0, "R9 sw bit cleared", sw_rst_bit_o, 0);
    tick();
    chk(nondet_o == !det, "R11 flag holds in idle", nondet_o, !det);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk(seq_state_o == 3'd0, "R1 reset state", seq_state_o, 0);
    chk({bnr_o, cpu_rst_o, refresh_clr_o, tracker_clr_o, sw_rst_bit_o, keep_cfg_o, nondet_o} == 7'd0,
        "R1 outputs zero", {bnr_o, cpu_rst_o, refresh_clr_o, tracker_clr_o,
        sw_rst_bit_o, keep_cfg_o, nondet_o}, 0);
    rst_n = 1;
    tick();
    chk(seq_state_o == 3'd0, "R1 idle after release", seq_state_o, 0);
    for (int e = 0; e < 2; e++)
      for (int k = 0; k < 2; k++)
        for (int b = 0; b < 2; b++)
          for (int g1 = 0; g1 < 3; g1++)
            for (int g2 = 0; g2 < 4; g2 += 1 + g2)
              run_seq(e[0], k[0], b[0], g1, g2);
    // restart of an aligned sequence by the external reset
    keep_mem_en = 1; cause_businit = 0;
    sw_rst_set = 1; tick(); sw_rst_set = 0;
    for (int i = 0; i < H + 2; i++) tick();
    maint_end = 1; tick(); maint_end = 0;
    chk(seq_state_o == 3'd3, "R4 reached toggle", seq_state_o, 3);
    ext_rst = 1; tick(); ext_rst = 0;
    chk(seq_state_o == 3'd1, "R3 restart from toggle", seq_state_o, 1);
    chk(nondet_o == 1'b1, "R11 restart nondet", nondet_o, 1);
    tick();
    chk(seq_state_o == 3'd4, "R11 direct release", seq_state_o, 4);
    for (int i = 0; i < RL; i++) tick();
    chk(seq_state_o == 3'd0 && sw_rst_bit_o == 1'b0, "R9 restart ends cleared",
        {seq_state_o, sw_rst_bit_o}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule